// File: doc/BRIEF.md
# Device-side Translation Buffer with Software Victim Index

This block is a small fully associative translation buffer for a device-side address translator. Each slot holds a tag word (virtual page, page-size code, valid flag) and a data word (physical page plus attribute bits). Mixed page sizes (16 MB, 1 MB, 64 KB, 4 KB) live side by side in the same array. A lookup stream takes a device virtual address and returns a hit flag and the translated physical address one cycle later.

Software manages the contents through plain strobes. A lock register carries a victim index, and every per-slot operation targets the slot that this index names. Those operations are reading back the slot's two words, invalidating it, and writing it from two staging words. The lock register also has a base field, which always reads zero. Installing a translation follows a fixed order. First, write both staging words. Second, pulse the single-slot flush. Third, pulse the load. After each load the victim index steps forward on its own. Software finds a free slot by stepping the victim index through the slots and testing the valid bit that comes back. A global flush empties the array and returns the victim index to zero.

The lookup port is valid/ready. A request is accepted when `lk_valid` and `lk_ready` are both high. `lk_ready` is low only while a response is held and `rsp_ready` is low. A response stays valid and unchanged until `rsp_ready` takes it. A lookup uses the table contents present before the clock edge that accepts it.

Top module: `iotlb_top`

## Requirements
- R1: After reset every slot is invalid, the victim index is 0, the base field is 0, `rsp_valid` is 0 and `lk_ready` is 1.
- R2: `rd_cam`/`rd_ram` show the slot named by the victim index. The tag word is laid out as [31:12] virtual page, bit 2 valid, [1:0] size code. The data word is laid out as [31:12] physical page and [11:0] attributes.
- R3: A `flush_entry` pulse clears only the valid bit (bit 2) of the selected slot. Other slots and the victim index are unchanged.
- R4: A `load_entry` pulse copies the staging words into the selected slot. The victim index then advances by one, and from ENTRIES-1 it wraps to 0.
- R5: The size code is 00 = 16 MB, 01 = 1 MB, 10 = 64 KB, 11 = 4 KB. A valid slot covers address `va` when start <= va < start + size. Here start is the tag with the bits below the page size cleared.
- R6: A `flush_all` pulse invalidates every slot and sets the victim index to 0. It takes priority over `lock_wr`, `load_entry` and `flush_entry` in the same cycle.
- R7: A lookup that no valid slot covers returns `rsp_hit` = 0 and `rsp_pa` = 0.
- R8: On a hit, `rsp_pa` takes the slot's physical page bits at and above the page size and the request's offset bits below it.
- R9: When several valid slots cover an address, the lowest-indexed one supplies the translation.
- R10: `lk_ready` = !rsp_valid || rsp_ready. The response appears the cycle after acceptance and is held stable while `rsp_ready` is low.
- R11: `lock_wr` loads the victim index from `lock_victim_in`, and a value of ENTRIES or more is ignored. If it coincides with `load_entry`, the load uses the old index and the written value wins over the advance. The base field always reads 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| stg_cam_wr | input | 1 | Write tag staging word |
| stg_cam_wdata | input | 32 | Tag staging data |
| stg_ram_wr | input | 1 | Write data staging word |
| stg_ram_wdata | input | 32 | Data staging data |
| lock_wr | input | 1 | Write victim index |
| lock_victim_in | input | IDX_W | New victim index |
| flush_entry | input | 1 | Invalidate selected slot |
| load_entry | input | 1 | Write staging words into selected slot |
| flush_all | input | 1 | Invalidate all, victim to zero |
| lock_base_out | output | IDX_W | Base field (reads zero) |
| lock_victim_out | output | IDX_W | Current victim index |
| rd_cam | output | 32 | Tag word of selected slot |
| rd_ram | output | 32 | Data word of selected slot |
| lk_valid | input | 1 | Lookup request valid |
| lk_ready | output | 1 | Lookup request ready |
| lk_va | input | 32 | Virtual address to translate |
| rsp_valid | output | 1 | Response valid |
| rsp_ready | input | 1 | Response consumer ready |
| rsp_hit | output | 1 | Translation found |
| rsp_pa | output | 32 | Translated physical address |

## Verification
The bench builds the block with ENTRIES = 8, so the index is three bits wide. With eight slots, a full sweep of loads brings the victim index round its wrap point in a few dozen cycles. The same sweep lets a scan read back every slot's valid bit. Because 8 is a power of two, an out-of-range index write cannot be driven, so that clause of R11 is left to the design assertions at larger, non-power-of-two counts. The default of 32 changes only the array width, not any control path.

// File: rtl/iotlb_pkg.sv
package iotlb_pkg;
  localparam int ADDR_W      = 32;
  localparam int PAGE_LSB    = 12;
  localparam int VALID_BIT   = 2;

  typedef enum logic [1:0] {
    PG_16M = 2'b00,
    PG_1M  = 2'b01,
    PG_64K = 2'b10,
    PG_4K  = 2'b11
  } pgsz_e;

  // Mask of the in-page offset bits for a size code.
  function automatic logic [ADDR_W-1:0] offset_mask(input logic [1:0] code);
    case (pgsz_e'(code))
      PG_16M:  offset_mask = 32'h00FF_FFFF;
      PG_1M:   offset_mask = 32'h000F_FFFF;
      PG_64K:  offset_mask = 32'h0000_FFFF;
      default: offset_mask = 32'h0000_0FFF;
    endcase
  endfunction
endpackage

// File: rtl/iotlb_victim_ctrl.sv
module iotlb_victim_ctrl #(
  parameter int ENTRIES = 32,
  parameter int IDX_W   = $clog2(ENTRIES)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             flush_all,
  input  logic             lock_wr,
  input  logic [IDX_W-1:0] lock_victim_in,
  input  logic             load_entry,
  output logic [IDX_W-1:0] victim
);
  localparam logic [IDX_W-1:0] LAST = IDX_W'(ENTRIES - 1);

  logic [IDX_W-1:0] victim_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      victim_q <= '0;
    end else if (flush_all) begin
      victim_q <= '0;
    end else if (lock_wr) begin
      // out-of-range indices are dropped
      if (int'(lock_victim_in) < ENTRIES) victim_q <= lock_victim_in;
    end else if (load_entry) begin
      victim_q <= (victim_q == LAST) ? '0 : victim_q + 1'b1;
    end
  end

  assign victim = victim_q;

  AST_LOAD_WRAP: assert property (@(posedge clk) disable iff (!rst_n)
    (load_entry && !flush_all && !lock_wr && victim_q == LAST) |=> (victim_q == '0)) // R4
    else $error("victim did not wrap");

  AST_GFLUSH_VICTIM: assert property (@(posedge clk) disable iff (!rst_n)
    flush_all |=> (victim_q == '0)) // R6
    else $error("victim not cleared by global flush");

  AST_VICTIM_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
    lock_wr && !flush_all |=> (int'(victim_q) < ENTRIES)) // R11
    else $error("victim out of range");
endmodule

// File: rtl/iotlb_store.sv
module iotlb_store
  import iotlb_pkg::*;
#(
  parameter int ENTRIES = 32,
  parameter int IDX_W   = $clog2(ENTRIES)
) (
  input  logic                           clk,
  input  logic                           rst_n,
  input  logic                           flush_all,
  input  logic                           flush_one,
  input  logic                           load,
  input  logic [IDX_W-1:0]               idx,
  input  logic [ADDR_W-1:0]              stg_cam,
  input  logic [ADDR_W-1:0]              stg_ram,
  output logic [ENTRIES-1:0][ADDR_W-1:0] cam_arr,
  output logic [ENTRIES-1:0][ADDR_W-1:0] ram_arr,
  output logic [ADDR_W-1:0]              rd_cam,
  output logic [ADDR_W-1:0]              rd_ram
);
  logic [ENTRIES-1:0] valid_vec;

  for (genvar i = 0; i < ENTRIES; i++) begin : g_slot
    logic [ADDR_W-1:0] cam_q;
    logic [ADDR_W-1:0] ram_q;
    logic              sel;

    assign sel = (idx == IDX_W'(i));

    always_ff @(posedge clk) begin
      if (!rst_n) begin
        cam_q <= '0;
        ram_q <= '0;
      end else if (flush_all) begin
        cam_q[VALID_BIT] <= 1'b0;
      end else if (load && sel) begin
        cam_q <= stg_cam;
        ram_q <= stg_ram;
      end else if (flush_one && sel) begin
        cam_q[VALID_BIT] <= 1'b0;
      end
    end

    assign cam_arr[i]   = cam_q;
    assign ram_arr[i]   = ram_q;
    assign valid_vec[i] = cam_q[VALID_BIT];
  end

  assign rd_cam = cam_arr[idx];
  assign rd_ram = ram_arr[idx];

  AST_GFLUSH_EMPTY: assert property (@(posedge clk) disable iff (!rst_n)
    flush_all |=> (valid_vec == '0)) // R6
    else $error("slots left valid after global flush");

  AST_FLUSH_ONE: assert property (@(posedge clk) disable iff (!rst_n)
    (flush_one && !load && !flush_all) |=> !rd_cam[VALID_BIT] || (idx != $past(idx))) // R3
    else $error("flushed slot still valid");

  AST_LOAD_COPY: assert property (@(posedge clk) disable iff (!rst_n)
    (load && !flush_all) |=> (cam_arr[$past(idx)] == $past(stg_cam))) // R4
    else $error("load did not copy staging word");
endmodule

// File: rtl/iotlb_match.sv
module iotlb_match
  import iotlb_pkg::*;
#(
  parameter int ENTRIES = 32
) (
  input  logic [ADDR_W-1:0]              va,
  input  logic [ENTRIES-1:0][ADDR_W-1:0] cam_arr,
  input  logic [ENTRIES-1:0][ADDR_W-1:0] ram_arr,
  output logic                           hit,
  output logic [ADDR_W-1:0]              pa
);
  logic [ENTRIES-1:0]             hit_vec;
  logic [ENTRIES-1:0][ADDR_W-1:0] pa_cand;

  for (genvar i = 0; i < ENTRIES; i++) begin : g_cmp
    logic [ADDR_W-1:0] m;
    assign m          = offset_mask(cam_arr[i][1:0]);
    assign hit_vec[i] = cam_arr[i][VALID_BIT] && (((va ^ cam_arr[i]) & ~m) == '0);
    assign pa_cand[i] = (ram_arr[i] & ~m) | (va & m);
  end

  // lowest index wins
  always_comb begin
    hit = 1'b0;
    pa  = '0;
    for (int i = ENTRIES - 1; i >= 0; i--) begin
      if (hit_vec[i]) begin
        hit = 1'b1;
        pa  = pa_cand[i];
      end
    end
  end
endmodule

// File: rtl/iotlb_top.sv
module iotlb_top
  import iotlb_pkg::*;
#(
  parameter int ENTRIES = 32,
  parameter int IDX_W   = $clog2(ENTRIES)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              stg_cam_wr,
  input  logic [31:0]       stg_cam_wdata,
  input  logic              stg_ram_wr,
  input  logic [31:0]       stg_ram_wdata,
  input  logic              lock_wr,
  input  logic [IDX_W-1:0]  lock_victim_in,
  input  logic              flush_entry,
  input  logic              load_entry,
  input  logic              flush_all,
  output logic [IDX_W-1:0]  lock_base_out,
  output logic [IDX_W-1:0]  lock_victim_out,
  output logic [31:0]       rd_cam,
  output logic [31:0]       rd_ram,
  input  logic              lk_valid,
  output logic              lk_ready,
  input  logic [31:0]       lk_va,
  output logic              rsp_valid,
  input  logic              rsp_ready,
  output logic              rsp_hit,
  output logic [31:0]       rsp_pa
);
  logic [ADDR_W-1:0]              stg_cam_q, stg_ram_q;
  logic [IDX_W-1:0]               victim;
  logic [ENTRIES-1:0][ADDR_W-1:0] cam_arr, ram_arr;
  logic                           m_hit;
  logic [ADDR_W-1:0]              m_pa;
  logic                           rsp_valid_q, rsp_hit_q;
  logic [ADDR_W-1:0]              rsp_pa_q;
  logic                           accept;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      stg_cam_q <= '0;
      stg_ram_q <= '0;
    end else begin
      if (stg_cam_wr) stg_cam_q <= stg_cam_wdata;
      if (stg_ram_wr) stg_ram_q <= stg_ram_wdata;
    end
  end

  iotlb_victim_ctrl #(.ENTRIES(ENTRIES), .IDX_W(IDX_W)) u_ctrl (
    .clk            (clk),
    .rst_n          (rst_n),
    .flush_all      (flush_all),
    .lock_wr        (lock_wr),
    .lock_victim_in (lock_victim_in),
    .load_entry     (load_entry),
    .victim         (victim)
  );

  iotlb_store #(.ENTRIES(ENTRIES), .IDX_W(IDX_W)) u_store (
    .clk       (clk),
    .rst_n     (rst_n),
    .flush_all (flush_all),
    .flush_one (flush_entry),
    .load      (load_entry),
    .idx       (victim),
    .stg_cam   (stg_cam_q),
    .stg_ram   (stg_ram_q),
    .cam_arr   (cam_arr),
    .ram_arr   (ram_arr),
    .rd_cam    (rd_cam),
    .rd_ram    (rd_ram)
  );

  iotlb_match #(.ENTRIES(ENTRIES)) u_match (
    .va      (lk_va),
    .cam_arr (cam_arr),
    .ram_arr (ram_arr),
    .hit     (m_hit),
    .pa      (m_pa)
  );

  assign lk_ready = !rsp_valid_q || rsp_ready;
  assign accept   = lk_valid && lk_ready;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rsp_valid_q <= 1'b0;
      rsp_hit_q   <= 1'b0;
      rsp_pa_q    <= '0;
    end else if (accept) begin
      rsp_valid_q <= 1'b1;
      rsp_hit_q   <= m_hit;
      rsp_pa_q    <= m_pa;
    end else if (rsp_ready) begin
      rsp_valid_q <= 1'b0;
    end
  end

  assign rsp_valid       = rsp_valid_q;
  assign rsp_hit         = rsp_hit_q;
  assign rsp_pa          = rsp_pa_q;
  assign lock_base_out   = '0;
  assign lock_victim_out = victim;

  AST_RSP_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && !rsp_ready) |=> (rsp_valid && $stable(rsp_pa) && $stable(rsp_hit))) // R10
    else $error("response changed under back-pressure");

  AST_MISS_PA_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && !rsp_hit) |-> (rsp_pa == '0)) // R7
    else $error("miss with nonzero address");

  AST_RSP_FOLLOWS_ACCEPT: assert property (@(posedge clk) disable iff (!rst_n)
    (lk_valid && lk_ready) |=> rsp_valid) // R10
    else $error("accepted request produced no response");
endmodule

// File: tb/tb_iotlb_top.sv
`timescale 1ns/1ps
module tb_iotlb_top;
  localparam int ENTRIES = 8;
  localparam int IDX_W   = 3;

  logic clk = 1'b0;
  logic rst_n;
  logic stg_cam_wr, stg_ram_wr, lock_wr, flush_entry, load_entry, flush_all;
  logic [31:0] stg_cam_wdata, stg_ram_wdata;
  logic [IDX_W-1:0] lock_victim_in, lock_base_out, lock_victim_out;
  logic [31:0] rd_cam, rd_ram, lk_va, rsp_pa;
  logic lk_valid, lk_ready, rsp_valid, rsp_ready, rsp_hit;

  int n_chk = 0, n_fail = 0;
  bit done = 1'b0;

  always #2.5 clk = ~clk;

  iotlb_top #(.ENTRIES(ENTRIES), .IDX_W(IDX_W)) dut (
    .clk(clk), .rst_n(rst_n),
    .stg_cam_wr(stg_cam_wr), .stg_cam_wdata(stg_cam_wdata),
    .stg_ram_wr(stg_ram_wr), .stg_ram_wdata(stg_ram_wdata),
    .lock_wr(lock_wr), .lock_victim_in(lock_victim_in),
    .flush_entry(flush_entry), .load_entry(load_entry), .flush_all(flush_all),
    .lock_base_out(lock_base_out), .lock_victim_out(lock_victim_out),
    .rd_cam(rd_cam), .rd_ram(rd_ram),
    .lk_valid(lk_valid), .lk_ready(lk_ready), .lk_va(lk_va),
    .rsp_valid(rsp_valid), .rsp_ready(rsp_ready), .rsp_hit(rsp_hit), .rsp_pa(rsp_pa)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic tick();
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic set_victim(input int v);
    lock_wr = 1'b1; lock_victim_in = IDX_W'(v);
    tick();
    lock_wr = 1'b0;
  endtask

  task automatic install(input logic [31:0] cam, input logic [31:0] ram);
    stg_cam_wr = 1'b1; stg_cam_wdata = cam;
    stg_ram_wr = 1'b1; stg_ram_wdata = ram;
    tick();
    stg_cam_wr = 1'b0; stg_ram_wr = 1'b0;
    flush_entry = 1'b1;
    tick();
    flush_entry = 1'b0; load_entry = 1'b1;
    tick();
    load_entry = 1'b0;
  endtask

  task automatic pulse_gflush();
    flush_all = 1'b1;
    tick();
    flush_all = 1'b0;
  endtask

  task automatic lookup(input string req, input logic [31:0] va,
                        input logic exp_hit, input logic [31:0] exp_pa);
    lk_valid = 1'b1; lk_va = va;
    tick();
    lk_valid = 1'b0;
    chk({req, " rsp_valid"}, 32'(rsp_valid), 32'd1);
    chk({req, " hit"}, 32'(rsp_hit), 32'(exp_hit));
    chk({req, " pa"}, rsp_pa, exp_pa);
    tick();
  endtask

  task automatic t_reset();
    chk("R1 victim", 32'(lock_victim_out), 0);
    chk("R1 base", 32'(lock_base_out), 0);
    chk("R1 rsp_valid", 32'(rsp_valid), 0);
    chk("R1 lk_ready", 32'(lk_ready), 1);
    for (int i = 0; i < ENTRIES; i++) begin
      set_victim(i);
      chk("R1 slot invalid", 32'(rd_cam[2]), 0);
    end
    set_victim(0);
    lookup("R1/R7 empty", 32'h1234_5678, 1'b0, 32'h0);
  endtask

  task automatic t_sizes();
    install(32'h1200_0004, 32'h8000_0000);
    install(32'h2030_0005, 32'h9010_0000);
    install(32'h3456_0006, 32'hA000_0000);
    install(32'h4000_1007, 32'hB000_2ABC);
    chk("R4 advance", 32'(lock_victim_out), 4);
    lookup("R5/R8 16M top", 32'h12FF_FFFF, 1'b1, 32'h80FF_FFFF);
    lookup("R5 16M above", 32'h1300_0000, 1'b0, 32'h0);
    lookup("R5 16M below", 32'h11FF_FFFF, 1'b0, 32'h0);
    lookup("R5/R8 1M", 32'h203A_BCDE, 1'b1, 32'h901A_BCDE);
    lookup("R5 1M above", 32'h2040_0000, 1'b0, 32'h0);
    lookup("R5/R8 64K", 32'h3456_FFF0, 1'b1, 32'hA000_FFF0);
    lookup("R5 64K above", 32'h3457_0000, 1'b0, 32'h0);
    lookup("R5/R8 4K", 32'h4000_1234, 1'b1, 32'hB000_2234);
    lookup("R5 4K above", 32'h4000_2000, 1'b0, 32'h0);
    set_victim(2);
    chk("R2 rd_cam", rd_cam, 32'h3456_0006);
    chk("R2 rd_ram", rd_ram, 32'hA000_0000);
  endtask

  task automatic t_flush_one();
    flush_entry = 1'b1;
    tick();
    flush_entry = 1'b0;
    chk("R3 valid cleared", rd_cam, 32'h3456_0002);
    chk("R3 victim kept", 32'(lock_victim_out), 2);
    lookup("R3 flushed miss", 32'h3456_FFF0, 1'b0, 32'h0);
    lookup("R3 neighbour kept", 32'h4000_1234, 1'b1, 32'hB000_2234);
  endtask

  task automatic t_overlap();
    set_victim(4);
    install(32'h1234_5007, 32'hC000_0000);
    lookup("R9 low index wins", 32'h1234_5678, 1'b1, 32'h8034_5678);
    set_victim(0);
    flush_entry = 1'b1;
    tick();
    flush_entry = 1'b0;
    lookup("R9 next slot", 32'h1234_5678, 1'b1, 32'hC000_0678);
  endtask

  task automatic t_wrap_scan();
    pulse_gflush();
    chk("R6 victim zero", 32'(lock_victim_out), 0);
    lookup("R6 empty", 32'h4000_1234, 1'b0, 32'h0);
    for (int i = 0; i < ENTRIES; i++)
      install(32'h5000_0007 | (32'(i) << 12), 32'hE000_0000 | (32'(i) << 12));
    chk("R4 wrap", 32'(lock_victim_out), 0);
    for (int i = 0; i < ENTRIES; i++) begin
      set_victim(i);
      chk("R4 scan valid", 32'(rd_cam[2]), 1);
    end
    set_victim(ENTRIES - 1);
    install(32'h5000_7007, 32'hF000_0000);
    chk("R4 wrap from last", 32'(lock_victim_out), 0);
    lookup("R4 reloaded", 32'h5000_7010, 1'b1, 32'hF000_0010);
  endtask

  task automatic t_lock_priority();
    set_victim(3);
    stg_cam_wr = 1'b1; stg_cam_wdata = 32'h7700_0007;
    stg_ram_wr = 1'b1; stg_ram_wdata = 32'h1100_0000;
    tick();
    stg_cam_wr = 1'b0; stg_ram_wr = 1'b0;
    load_entry = 1'b1; lock_wr = 1'b1; lock_victim_in = 3'd6;
    tick();
    load_entry = 1'b0; lock_wr = 1'b0;
    chk("R11 write beats advance", 32'(lock_victim_out), 6);
    chk("R11 base zero", 32'(lock_base_out), 0);
    set_victim(3);
    chk("R11 load used old index", rd_cam, 32'h7700_0007);
  endtask

  task automatic t_gflush_priority();
    flush_all = 1'b1; load_entry = 1'b1; lock_wr = 1'b1; lock_victim_in = 3'd5;
    tick();
    flush_all = 1'b0; load_entry = 1'b0; lock_wr = 1'b0;
    chk("R6 priority victim", 32'(lock_victim_out), 0);
    for (int i = 0; i < ENTRIES; i++) begin
      set_victim(i);
      chk("R6 slot invalid", 32'(rd_cam[2]), 0);
    end
    set_victim(0);
  endtask

  task automatic t_backpressure();
    install(32'h6000_0007, 32'hD000_0000);
    rsp_ready = 1'b0;
    lk_valid = 1'b1; lk_va = 32'h6000_0111;
    tick();
    chk("R10 first rsp", rsp_pa, 32'hD000_0111);
    chk("R10 ready low", 32'(lk_ready), 0);
    lk_va = 32'h6000_0222;
    tick();
    chk("R10 held valid", 32'(rsp_valid), 1);
    chk("R10 held pa", rsp_pa, 32'hD000_0111);
    rsp_ready = 1'b1;
    #0.1;
    chk("R10 ready follows", 32'(lk_ready), 1);
    tick();
    lk_valid = 1'b0;
    chk("R10 second rsp", rsp_pa, 32'hD000_0222);
    tick();
    chk("R10 drained", 32'(rsp_valid), 0);
  endtask

  initial begin
    rst_n = 1'b0;
    stg_cam_wr = 0; stg_ram_wr = 0; lock_wr = 0; flush_entry = 0;
    load_entry = 0; flush_all = 0; stg_cam_wdata = 0; stg_ram_wdata = 0;
    lock_victim_in = 0; lk_valid = 0; lk_va = 0; rsp_ready = 1'b1;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_sizes();
    t_flush_one();
    t_overlap();
    t_wrap_scan();
    t_lock_priority();
    t_gflush_priority();
    t_backpressure();
    done = 1'b1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog: actual hung expected done");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end
endmodule